// File: doc/BRIEF.md
# Partitioned Frame Buffer Admission Controller

This block keeps the slot accounting for a shared frame buffer and decides whether a classified frame keeps its slot. An arriving frame, whose destination class and source port are still unknown, first asks for a slot in a temporary holding region. Once classification is done, an admission request carries the frame tag, its priority class (0 lowest, 7 highest) and its source port. The block then charges the slot to one of several regions, or drops the frame. When a frame leaves the buffer, a release request with its tag returns the slot to the region it was charged to.

The regions are:
- a temporary region for unclassified frames;
- one reserved region for each of the six highest classes (2 to 7);
- one reserved region for each of five source ports (four gigabit ports and the CPU port);
- a single shared pool.

Every region limit is a configuration input. The block only counts and decides. It does not allocate slot addresses and does not store frame data.

Top module: `frame_buffer_admit`

## Requirements
- R1: After reset every occupancy count (temporary, shared, each class region, each port region) is zero, and `alloc_gnt`, `adm_accept` and `adm_drop` are low while no request is present.
- R2: `alloc_gnt` is high in the same cycle as `alloc_req` exactly when `temp_used` is below `cfg_temp_slots`. A granted allocation raises `temp_used` by one at the next clock edge, and a refused one leaves it unchanged.
- R3: Every admission request, whether accepted or dropped, gives back its temporary slot: `temp_used` falls by one at the next edge, in the same cycle as the decision.
- R4: For a frame of class c with c >= 2, the slot goes to class region c-2 when that region's count is below its limit. `adm_region` then reads 0.
- R5: If the class region is missing or full, the slot goes to the source-port region when the port id is 0 to 4 and that region's count is below its limit. `adm_region` then reads 1. Port ids 5 to 7 have no port region.
- R6: If neither reservation has room, the slot goes to the shared pool when `shared_used` is below `cfg_shared_slots`, and `adm_region` reads 2. Otherwise `adm_drop` is high, `adm_accept` is low and no region count changes. Exactly one of `adm_accept` and `adm_drop` is high for each admission request.
- R7: Frames of class 0 or 1 are never charged to a class region. They go straight to the port-then-shared order.
- R8: A release decrements the count of the region and index that were recorded for its tag at admission, and frees the tag. A release for a tag that holds no slot changes no count.
- R9: An allocation, an admission and a release of a different tag in the same cycle are all applied. The admission decision uses the counts from before that edge.
- R10: A region count rises by one at the edge after an accepted admission charged to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_temp_slots | input | CW | Temporary region limit |
| cfg_class_slots | input | NRC x CW | Per-class reserved limits, index = class - 2 |
| cfg_port_slots | input | NP x CW | Per-source-port reserved limits |
| cfg_shared_slots | input | CW | Shared pool limit |
| alloc_req | input | 1 | Arriving frame asks for a temporary slot |
| alloc_gnt | output | 1 | Temporary slot granted (same cycle) |
| adm_req | input | 1 | Classified frame asks for admission |
| adm_tag | input | TAG_W | Tag of the frame being admitted |
| adm_class | input | 3 | Priority class of the frame |
| adm_port | input | 3 | Source port id of the frame |
| adm_accept | output | 1 | Frame admitted (same cycle) |
| adm_drop | output | 1 | Frame dropped (same cycle) |
| adm_region | output | 2 | Charged region: 0 class, 1 port, 2 shared, 3 none |
| rel_req | input | 1 | Frame leaves the buffer |
| rel_tag | input | TAG_W | Tag of the leaving frame |
| temp_used | output | CW | Temporary region occupancy |
| shared_used | output | CW | Shared pool occupancy |
| class_used | output | NRC x CW | Per-class region occupancy |
| port_used | output | NP x CW | Per-port region occupancy |

## Verification
A corrupted count or tag record does not stay hidden. One edge later it shows up as an occupancy output that differs from the model. At the first admission that reaches the affected region, it also shows up as a wrong choice of region or a wrong drop. A release that returns a slot to the wrong region shows two errors on the next edge: one count too high and another too low. The bench compares every occupancy output on every cycle against its own model, so a divergence is caught within one clock. Small limits keep all regions near full, so every level of the fallback order is exercised.

// File: rtl/fba_pkg.sv
package fba_pkg;
    typedef enum logic [1:0] {
        RGN_CLASS  = 2'd0,
        RGN_PORT   = 2'd1,
        RGN_SHARED = 2'd2,
        RGN_NONE   = 2'd3
    } region_e;
endpackage

// File: rtl/fba_region_select.sv
module fba_region_select
    import fba_pkg::*;
#(
    parameter int NCLS  = 8,
    parameter int NRC   = 6,
    parameter int NP    = 5,
    parameter int CW    = 6,
    parameter int CLS_W = 3,
    parameter int PRT_W = 3,
    parameter int IW    = 3
) (
    input  logic [CLS_W-1:0]        cls_id,
    input  logic [PRT_W-1:0]        prt_id,
    input  logic [NRC-1:0][CW-1:0]  cls_cnt,
    input  logic [NRC-1:0][CW-1:0]  cls_lim,
    input  logic [NP-1:0][CW-1:0]   prt_cnt,
    input  logic [NP-1:0][CW-1:0]   prt_lim,
    input  logic [CW-1:0]           shr_cnt,
    input  logic [CW-1:0]           shr_lim,
    output region_e                 sel_rgn,
    output logic [IW-1:0]           sel_idx
);
    localparam int LOW_CLS = NCLS - NRC;

    logic          cls_room;
    logic          prt_room;
    logic [IW-1:0] cls_idx;

    always_comb begin
        cls_room = 1'b0;
        cls_idx  = '0;
        for (int i = 0; i < NRC; i++) begin
            if (int'(cls_id) == LOW_CLS + i) begin
                cls_idx  = IW'(i);
                cls_room = cls_cnt[i] < cls_lim[i];
            end
        end
    end

    always_comb begin
        prt_room = 1'b0;
        for (int j = 0; j < NP; j++) begin
            if (int'(prt_id) == j) begin
                prt_room = prt_cnt[j] < prt_lim[j];
            end
        end
    end

    always_comb begin
        sel_rgn = RGN_NONE;
        sel_idx = '0;
        if (cls_room) begin
            sel_rgn = RGN_CLASS;
            sel_idx = cls_idx;
        end else if (prt_room) begin
            sel_rgn = RGN_PORT;
            sel_idx = IW'(prt_id);
        end else if (shr_cnt < shr_lim) begin
            sel_rgn = RGN_SHARED;
        end
    end
endmodule

// File: rtl/fba_tag_store.sv
module fba_tag_store
    import fba_pkg::*;
#(
    parameter int NT    = 16,
    parameter int TAG_W = 4,
    parameter int IW    = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [TAG_W-1:0] wr_tag,
    input  region_e          wr_rgn,
    input  logic [IW-1:0]    wr_idx,
    input  logic             clr_en,
    input  logic [TAG_W-1:0] rd_tag,
    output logic             rd_vld,
    output region_e          rd_rgn,
    output logic [IW-1:0]    rd_idx
);
    typedef struct packed {
        logic [NT-1:0]          vld;
        logic [NT-1:0][1:0]     rgn;
        logic [NT-1:0][IW-1:0]  idx;
    } tag_state_t;

    tag_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int t = 0; t < NT; t++) begin
            if (clr_en && rd_tag == TAG_W'(t)) begin
                st_d.vld[t] = 1'b0;
            end
            if (wr_en && wr_tag == TAG_W'(t)) begin
                st_d.vld[t] = 1'b1;
                st_d.rgn[t] = wr_rgn;
                st_d.idx[t] = wr_idx;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_vld = st_q.vld[rd_tag];
    assign rd_rgn = region_e'(st_q.rgn[rd_tag]);
    assign rd_idx = st_q.idx[rd_tag];

    AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_en && !(wr_en && wr_tag == rd_tag)) |=> !st_q.vld[$past(rd_tag)]); // R8
endmodule

// File: rtl/frame_buffer_admit.sv
module frame_buffer_admit
    import fba_pkg::*;
#(
    parameter int NCLS  = 8,
    parameter int NRC   = 6,
    parameter int NP    = 5,
    parameter int CW    = 6,
    parameter int NT    = 16,
    parameter int TAG_W = $clog2(NT),
    parameter int CLS_W = 3,
    parameter int PRT_W = 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [CW-1:0]          cfg_temp_slots,
    input  logic [NRC-1:0][CW-1:0] cfg_class_slots,
    input  logic [NP-1:0][CW-1:0]  cfg_port_slots,
    input  logic [CW-1:0]          cfg_shared_slots,
    input  logic                   alloc_req,
    output logic                   alloc_gnt,
    input  logic                   adm_req,
    input  logic [TAG_W-1:0]       adm_tag,
    input  logic [CLS_W-1:0]       adm_class,
    input  logic [PRT_W-1:0]       adm_port,
    output logic                   adm_accept,
    output logic                   adm_drop,
    output logic [1:0]             adm_region,
    input  logic                   rel_req,
    input  logic [TAG_W-1:0]       rel_tag,
    output logic [CW-1:0]          temp_used,
    output logic [CW-1:0]          shared_used,
    output logic [NRC-1:0][CW-1:0] class_used,
    output logic [NP-1:0][CW-1:0]  port_used
);
    localparam int IW = ($clog2(NRC) > $clog2(NP)) ? $clog2(NRC) : $clog2(NP);

    typedef struct packed {
        logic [CW-1:0]          temp;
        logic [CW-1:0]          shr;
        logic [NRC-1:0][CW-1:0] cls;
        logic [NP-1:0][CW-1:0]  prt;
    } occ_t;

    occ_t occ_d, occ_q;

    region_e       sel_rgn;
    logic [IW-1:0] sel_idx;
    region_e       rel_rgn;
    logic [IW-1:0] rel_idx;
    logic          rel_vld;
    logic          rel_hit;

    fba_region_select #(
        .NCLS(NCLS), .NRC(NRC), .NP(NP), .CW(CW),
        .CLS_W(CLS_W), .PRT_W(PRT_W), .IW(IW)
    ) u_select (
        .cls_id (adm_class),
        .prt_id (adm_port),
        .cls_cnt(occ_q.cls),
        .cls_lim(cfg_class_slots),
        .prt_cnt(occ_q.prt),
        .prt_lim(cfg_port_slots),
        .shr_cnt(occ_q.shr),
        .shr_lim(cfg_shared_slots),
        .sel_rgn(sel_rgn),
        .sel_idx(sel_idx)
    );

    assign alloc_gnt  = alloc_req && (occ_q.temp < cfg_temp_slots);
    assign adm_accept = adm_req && (sel_rgn != RGN_NONE);
    assign adm_drop   = adm_req && (sel_rgn == RGN_NONE);
    assign adm_region = sel_rgn;
    assign rel_hit    = rel_req && rel_vld;

    fba_tag_store #(.NT(NT), .TAG_W(TAG_W), .IW(IW)) u_tags (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (adm_accept),
        .wr_tag(adm_tag),
        .wr_rgn(sel_rgn),
        .wr_idx(sel_idx),
        .clr_en(rel_hit),
        .rd_tag(rel_tag),
        .rd_vld(rel_vld),
        .rd_rgn(rel_rgn),
        .rd_idx(rel_idx)
    );

    always_comb begin
        occ_d = occ_q;
        occ_d.temp = occ_q.temp + CW'(alloc_gnt) - CW'(adm_req);
        occ_d.shr  = occ_q.shr
                   + CW'(adm_accept && sel_rgn == RGN_SHARED)
                   - CW'(rel_hit && rel_rgn == RGN_SHARED);
        for (int i = 0; i < NRC; i++) begin
            occ_d.cls[i] = occ_q.cls[i]
                + CW'(adm_accept && sel_rgn == RGN_CLASS && sel_idx == IW'(i))
                - CW'(rel_hit && rel_rgn == RGN_CLASS && rel_idx == IW'(i));
        end
        for (int j = 0; j < NP; j++) begin
            occ_d.prt[j] = occ_q.prt[j]
                + CW'(adm_accept && sel_rgn == RGN_PORT && sel_idx == IW'(j))
                - CW'(rel_hit && rel_rgn == RGN_PORT && rel_idx == IW'(j));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            occ_q <= '0;
        end else begin
            occ_q <= occ_d;
        end
    end

    assign temp_used   = occ_q.temp;
    assign shared_used = occ_q.shr;
    assign class_used  = occ_q.cls;
    assign port_used   = occ_q.prt;

    AST_ALLOC_COUNTS: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_gnt && !adm_req) |=> temp_used == $past(temp_used) + CW'(1)); // R2
    AST_ADMIT_FREES_TEMP: assert property (@(posedge clk) disable iff (!rst_n)
        (adm_req && !alloc_gnt) |=> temp_used == $past(temp_used) - CW'(1)); // R3
    AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
        adm_req |-> $countones({adm_accept, adm_drop}) == 1); // R6
    AST_LOW_CLASS_NO_RESV: assert property (@(posedge clk) disable iff (!rst_n)
        (adm_accept && int'(adm_class) < NCLS - NRC) |-> sel_rgn != RGN_CLASS); // R7
    AST_SHARED_GROWS: assert property (@(posedge clk) disable iff (!rst_n)
        (adm_accept && sel_rgn == RGN_SHARED && !(rel_hit && rel_rgn == RGN_SHARED))
        |=> shared_used == $past(shared_used) + CW'(1)); // R10
    AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!alloc_req && !adm_req && !rel_req) |=> $stable(occ_q)); // R8
endmodule

// File: tb/tb_frame_buffer_admit.sv
module tb_frame_buffer_admit;
    localparam int NRC = 6, NP = 5, CW = 6, NT = 16, TW = 4;
    localparam int TEMP_LIM = 6, CLS_LIM = 2, PRT_LIM = 1, SHR_LIM = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [CW-1:0] cfg_temp_slots, cfg_shared_slots;
    logic [NRC-1:0][CW-1:0] cfg_class_slots;
    logic [NP-1:0][CW-1:0] cfg_port_slots;
    logic alloc_req = 0, alloc_gnt, adm_req = 0, adm_accept, adm_drop, rel_req = 0;
    logic [TW-1:0] adm_tag = '0, rel_tag = '0;
    logic [2:0] adm_class = '0, adm_port = '0;
    logic [1:0] adm_region;
    logic [CW-1:0] temp_used, shared_used;
    logic [NRC-1:0][CW-1:0] class_used;
    logic [NP-1:0][CW-1:0] port_used;

    int checks = 0, errors = 0;
    int m_temp = 0, m_shr = 0;
    int m_cls[NRC];
    int m_prt[NP];
    int t_rgn[NT];
    int t_idx[NT];

    always #10 clk = ~clk;

    frame_buffer_admit dut (.*);

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic check_state(input string req);
        chk(int'(temp_used) == m_temp, {req, " temp"}, int'(temp_used), m_temp);
        chk(int'(shared_used) == m_shr, {req, " shared"}, int'(shared_used), m_shr);
        for (int i = 0; i < NRC; i++)
            chk(int'(class_used[i]) == m_cls[i], {req, " class"}, int'(class_used[i]), m_cls[i]);
        for (int j = 0; j < NP; j++)
            chk(int'(port_used[j]) == m_prt[j], {req, " port"}, int'(port_used[j]), m_prt[j]);
    endtask

    // expected region: 0 class, 1 port, 2 shared, 3 drop; idx via output
    function automatic int exp_region(input int c, input int p, output int idx);
        idx = 0;
        if (c >= 2 && m_cls[c-2] < CLS_LIM) begin idx = c - 2; return 0; end
        if (p < NP && m_prt[p] < PRT_LIM) begin idx = p; return 1; end
        if (m_shr < SHR_LIM) return 2;
        return 3;
    endfunction

    task automatic cycle(input bit a, input bit ad, input int tag, input int c, input int p,
                         input bit r, input int rt, input string sreq);
        int er, ei;
        bit eg;
        string lbl;
        @(negedge clk);
        alloc_req = a; adm_req = ad; adm_tag = TW'(tag); adm_class = 3'(c);
        adm_port = 3'(p); rel_req = r; rel_tag = TW'(rt);
        #2;
        eg = a && (m_temp < TEMP_LIM);
        chk(alloc_gnt == eg, "R2 grant", int'(alloc_gnt), int'(eg));
        er = 3;
        if (ad) begin
            er = exp_region(c, p, ei);
            lbl = (c < 2) ? "R7" : (er == 0) ? "R4" : (er == 1) ? "R5" : "R6";
            chk(adm_accept == (er != 3), {lbl, " accept"}, int'(adm_accept), int'(er != 3));
            chk(adm_drop == (er == 3), "R6 drop", int'(adm_drop), int'(er == 3));
            if (er != 3) chk(int'(adm_region) == er, {lbl, " region"}, int'(adm_region), er);
        end
        m_temp += int'(eg) - int'(ad);
        if (r && t_rgn[rt] >= 0) begin
            case (t_rgn[rt])
                0: m_cls[t_idx[rt]]--;
                1: m_prt[t_idx[rt]]--;
                default: m_shr--;
            endcase
            t_rgn[rt] = -1;
        end
        if (ad && er != 3) begin
            case (er)
                0: m_cls[ei]++;
                1: m_prt[ei]++;
                default: m_shr++;
            endcase
            t_rgn[tag] = er; t_idx[tag] = ei;
        end
        @(posedge clk); #2;
        alloc_req = 0; adm_req = 0; rel_req = 0;
        check_state(sreq);
    endtask

    initial begin
        #4_000_000;
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int seed, tg, rt;
        bit do_ad;
        seed = 32'd1234;
        void'($urandom(seed));
        cfg_temp_slots = CW'(TEMP_LIM);
        cfg_shared_slots = CW'(SHR_LIM);
        for (int i = 0; i < NRC; i++) cfg_class_slots[i] = CW'(CLS_LIM);
        for (int j = 0; j < NP; j++) cfg_port_slots[j] = CW'(PRT_LIM);
        for (int i = 0; i < NRC; i++) m_cls[i] = 0;
        for (int j = 0; j < NP; j++) m_prt[j] = 0;
        for (int t = 0; t < NT; t++) begin t_rgn[t] = -1; t_idx[t] = 0; end
        repeat (3) @(posedge clk);
        #2;
        check_state("R1");
        chk(!alloc_gnt && !adm_accept && !adm_drop, "R1 outputs", 0, 0);
        rst_n = 1'b1;
        // fill temporary region; the seventh request is refused (R2)
        for (int k = 0; k < 7; k++) cycle(1, 0, 0, 0, 0, 0, 0, "R2");
        cycle(0, 1, 0, 0, 0, 0, 0, "R7");   // class 0 -> port 0
        cycle(0, 1, 1, 1, 0, 0, 0, "R6");   // port 0 full -> shared
        cycle(0, 1, 2, 7, 0, 0, 0, "R4");   // class 7 region
        cycle(0, 1, 3, 7, 0, 0, 0, "R4");
        cycle(0, 1, 4, 7, 6, 0, 0, "R5");   // port 6 has no region -> shared
        cycle(0, 1, 5, 7, 6, 0, 0, "R6");   // shared now full
        cycle(1, 1, 6, 7, 7, 0, 0, "R6");   // drop
        cycle(1, 1, 7, 2, 1, 1, 1, "R9");   // alloc + admit + release together
        cycle(0, 0, 0, 0, 0, 1, 9, "R8");   // unheld tag: no change
        cycle(0, 0, 0, 0, 0, 1, 2, "R8");   // class slot returns
        for (int n = 0; n < 4000; n++) begin
            do_ad = ($urandom % 2 == 0) && (m_temp > 0);
            tg = -1;
            if (do_ad) begin
                int st;
                st = $urandom % NT;
                for (int q = 0; q < NT; q++)
                    if (tg < 0 && t_rgn[(st + q) % NT] < 0) tg = (st + q) % NT;
                if (tg < 0) do_ad = 0;
            end
            rt = $urandom % NT;
            if (tg >= 0 && rt == tg) rt = (rt + 1) % NT;
            cycle($urandom % 2 == 0, do_ad, (tg < 0) ? 0 : tg, $urandom % 8, $urandom % 8,
                  $urandom % 5 < 2, rt, "R9");
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule